// File: doc/BRIEF.md
# Fixed-Tree Expression Engine

This block evaluates a complete arithmetic/relational expression in response to a single 8-bit reference. Expression definitions are held in an internal table of 256 packed words. When the engine is idle and `start` is raised, it latches the definition selected by `expr_idx`. It then resolves six leaf operands against a private 256-byte data memory, one leaf at a time. Each leaf has its own addressing mode: literal, direct read, address-of, or pointer indirection.

After the leaves are resolved, the engine walks a hard-wired three-level binary tree. Two bottom nodes multiply or divide. Two middle nodes add or subtract. The root either compares the two branch values or ANDs them bitwise. The root value can be written back to a destination byte, or it can be discarded. A compare outcome is also kept on a flag for later branch decisions.

Software fills the definition table and the data memory through simple write ports. It inspects memory through a read port. Both write ports are honoured only while the engine is idle.

Top module: `expr_tree_engine`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. It latches the table entry at `expr_idx`, and `busy` is high on the following cycle. A `start` raised while `busy` is high has no effect on the running evaluation or its timing.
- R2: Definition word layout (88 bits): bits [87:86] low-left op, [85:84] mid-left op, [83:82] root op, [81:80] mid-right op, [79:78] low-right op. Leaf k mode is at [77-3k -: 3] and leaf k operand at [59-8k -: 8], for k = 0..5. Destination mode is at [11:9], bit 8 is unused, and the destination address is at [7:0]. The tree computes left = (L0 op L1) op L2, right = L3 op (L4 op L5), root = left op right.
- R3: Leaf mode 7 uses the operand as a literal. Mode 0 reads memory at the operand address. Mode 1 yields the operand address itself. Mode 2 reads memory at the operand address and then reads memory at that value. Modes 3 to 6 behave as literals.
- R4: A bottom-node op with bit0 = 0 gives the low 8 bits of the unsigned product; bit0 = 1 gives the unsigned quotient. A middle-node op with bit0 = 0 adds and with bit0 = 1 subtracts, both modulo 256.
- R5: Root op 0 returns 1 if left < right, else 0. Root op 1 returns 1 if left > right, else 0. Root ops 2 and 3 return left AND right.
- R6: A divide by zero yields 255, sets `div_err`, and does not stall the engine. `div_err` stays high until reset.
- R7: Each leaf takes one cycle, plus one extra cycle for each mode-2 leaf. Then come three compute cycles, then one store cycle if a store is requested. After that, `done` is high for exactly one cycle, with `busy` low. `busy` is high in every earlier cycle of the evaluation.
- R8: Destination mode 0 writes the root value to the destination address. Any other destination mode leaves the data memory unchanged.
- R9: `result` shows the root value from the last evaluation and holds it until the next evaluation. `cmp_flag` is updated only by roots with op 0 or 1, and holds otherwise.
- R10: Writes to the definition table and to the data memory are ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `result`, `cmp_flag` and `div_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an evaluation |
| expr_idx | input | 8 | Index of the expression to evaluate |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Root value of the last evaluation |
| cmp_flag | output | 1 | Outcome of the last compare root |
| div_err | output | 1 | Sticky divide-by-zero indicator |
| def_we | input | 1 | Definition table write enable |
| def_waddr | input | 8 | Definition table write index |
| def_wdata | input | 88 | Definition word to write |
| mem_we | input | 1 | Data memory write enable |
| mem_waddr | input | 8 | Data memory write address |
| mem_wdata | input | 8 | Data memory write byte |
| mem_raddr | input | 8 | Data memory read address |
| mem_rdata | output | 8 | Data memory byte at `mem_raddr` |

## Verification
The bound checker watches the handshake on every cycle. It checks that `busy` and `done` are never high together and that `done` lasts a single cycle. It checks that `busy` only rises after an accepted `start`, that `div_err` never falls, and that `cmp_flag` only moves on compare roots. It also checks that compare roots yield 0 or 1. Operand resolution through each addressing mode, the tree arithmetic with its wrap-around, the exact latency with indirect leaves and stores, and the suppression of writes and starts while busy can only be shown by the bench. The bench does this by running crafted definitions against its own model and reading memory back afterwards.

// File: rtl/expr_tree_pkg.sv
package expr_tree_pkg;

    parameter int DW    = 8;   // data width
    parameter int AW    = 8;   // data memory address width
    parameter int IW    = 8;   // expression index width
    parameter int MW    = 3;   // addressing mode width
    parameter int OW    = 2;   // operator code width
    parameter int NLEAF = 6;   // leaves of the fixed tree

    localparam int DEF_W    = 5*OW + NLEAF*MW + NLEAF*AW + MW + 1 + AW;
    localparam int TBL_D    = 1 << IW;
    localparam int MEM_D    = 1 << AW;
    localparam int KW       = $clog2(NLEAF);

    localparam logic [MW-1:0] MODE_DIR  = 3'd0;
    localparam logic [MW-1:0] MODE_ADDR = 3'd1;
    localparam logic [MW-1:0] MODE_IND  = 3'd2;
    localparam logic [MW-1:0] MODE_IMM  = 3'd7;
    localparam logic [MW-1:0] DEST_STORE = 3'd0;

    localparam logic [OW-1:0] ROOT_LT = 2'd0;
    localparam logic [OW-1:0] ROOT_GT = 2'd1;

    typedef struct packed {
        logic [OW-1:0]                  op_ll;
        logic [OW-1:0]                  op_lm;
        logic [OW-1:0]                  op_root;
        logic [OW-1:0]                  op_rm;
        logic [OW-1:0]                  op_rl;
        logic [0:NLEAF-1][MW-1:0]       mode;
        logic [0:NLEAF-1][AW-1:0]       opnd;
        logic [MW-1:0]                  dmode;
        logic                           spare;
        logic [AW-1:0]                  daddr;
    } expr_def_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEAF, ST_IND, ST_L1, ST_L2, ST_L3, ST_STORE, ST_DONE
    } eng_state_t;

    // bottom node: {divide_by_zero, value}
    function automatic logic [DW:0] low_node(logic [OW-1:0] op,
                                             logic [DW-1:0] a, logic [DW-1:0] b);
        logic [2*DW-1:0] prod;
        if (op[0]) begin
            if (b == '0) return {1'b1, {DW{1'b1}}};
            return {1'b0, a / b};
        end
        prod = a * b;
        return {1'b0, prod[DW-1:0]};
    endfunction

    function automatic logic [DW-1:0] mid_node(logic [OW-1:0] op,
                                               logic [DW-1:0] a, logic [DW-1:0] b);
        return op[0] ? (a - b) : (a + b);
    endfunction

    function automatic logic [DW-1:0] root_node(logic [OW-1:0] op,
                                                logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            ROOT_LT: return DW'(a < b);
            ROOT_GT: return DW'(a > b);
            default: return a & b;
        endcase
    endfunction

    function automatic logic root_is_cmp(logic [OW-1:0] op);
        return (op == ROOT_LT) || (op == ROOT_GT);
    endfunction

endpackage

// File: rtl/expr_def_table.sv
module expr_def_table
    import expr_tree_pkg::*;
#(
    parameter int W_IDX = IW,
    parameter int W_DEF = DEF_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [W_IDX-1:0] waddr,
    input  logic [W_DEF-1:0] wdata,
    input  logic [W_IDX-1:0] raddr,
    output logic [W_DEF-1:0] rdata
);
    localparam int DEPTH = 1 << W_IDX;

    logic [W_DEF-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/expr_data_ram.sv
module expr_data_ram
    import expr_tree_pkg::*;
#(
    parameter int W_A = AW,
    parameter int W_D = DW
) (
    input  logic           clk,
    input  logic           we,
    input  logic [W_A-1:0] waddr,
    input  logic [W_D-1:0] wdata,
    input  logic [W_A-1:0] ra_a,
    output logic [W_D-1:0] rd_a,
    input  logic [W_A-1:0] ra_b,
    output logic [W_D-1:0] rd_b
);
    localparam int DEPTH = 1 << W_A;

    logic [W_D-1:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) bytes_q[waddr] <= wdata;
    end

    assign rd_a = bytes_q[ra_a];
    assign rd_b = bytes_q[ra_b];
endmodule

// File: rtl/expr_tree_nodes.sv
module expr_tree_nodes
    import expr_tree_pkg::*;
(
    input  expr_def_t                 def_i,
    input  logic [0:NLEAF-1][DW-1:0]  leaf_i,
    input  logic [0:1][DW-1:0]        low_i,
    input  logic [0:1][DW-1:0]        mid_i,
    output logic [0:1][DW-1:0]        low_o,
    output logic [0:1][DW-1:0]        mid_o,
    output logic [1:0]                dz_o,
    output logic [DW-1:0]             root_o
);
    for (genvar g = 0; g < 2; g++) begin : g_branch
        localparam bit LEFT = (g == 0);
        logic [OW-1:0] op_lo, op_mi;
        logic [DW-1:0] la, lb, ma, mb;
        logic [DW:0]   lr;

        always_comb begin
            if (LEFT) begin
                op_lo = def_i.op_ll;  op_mi = def_i.op_lm;
                la = leaf_i[0];  lb = leaf_i[1];
                ma = low_i[0];   mb = leaf_i[2];
            end else begin
                op_lo = def_i.op_rl;  op_mi = def_i.op_rm;
                la = leaf_i[4];  lb = leaf_i[5];
                ma = leaf_i[3];  mb = low_i[1];
            end
            lr = low_node(op_lo, la, lb);
        end

        assign low_o[g] = lr[DW-1:0];
        assign dz_o[g]  = lr[DW];
        assign mid_o[g] = mid_node(op_mi, ma, mb);
    end

    assign root_o = root_node(def_i.op_root, mid_i[0], mid_i[1]);
endmodule

// File: rtl/expr_tree_engine.sv
module expr_tree_engine
    import expr_tree_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IW-1:0]    expr_idx,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    result,
    output logic             cmp_flag,
    output logic             div_err,
    input  logic             def_we,
    input  logic [IW-1:0]    def_waddr,
    input  logic [DEF_W-1:0] def_wdata,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_waddr,
    input  logic [DW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_raddr,
    output logic [DW-1:0]    mem_rdata
);
    eng_state_t               state_q;
    expr_def_t                def_q;
    logic [DEF_W-1:0]         tbl_rdata;
    logic [KW-1:0]            leaf_k;
    logic [AW-1:0]            ptr_q;
    logic [0:NLEAF-1][DW-1:0] leaf_q;
    logic [0:1][DW-1:0]       low_q, mid_q, low_d, mid_d;
    logic [1:0]               dz_d;
    logic [DW-1:0]            root_d, result_q;
    logic                     flag_q, err_q;

    logic                     ram_we;
    logic [AW-1:0]            ram_waddr, ram_ra;
    logic [DW-1:0]            ram_wdata, ram_rd;
    logic                     idle;
    logic                     accept;
    logic                     last_leaf;

    assign idle      = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign accept    = idle && start;
    assign last_leaf = (leaf_k == KW'(NLEAF-1));

    expr_def_table u_table (
        .clk   (clk),
        .we    (def_we && idle),
        .waddr (def_waddr),
        .wdata (def_wdata),
        .raddr (expr_idx),
        .rdata (tbl_rdata)
    );

    assign ram_ra    = (state_q == ST_IND) ? ptr_q : def_q.opnd[leaf_k];
    assign ram_we    = (state_q == ST_STORE) || (mem_we && idle);
    assign ram_waddr = (state_q == ST_STORE) ? def_q.daddr : mem_waddr;
    assign ram_wdata = (state_q == ST_STORE) ? result_q : mem_wdata;

    expr_data_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .ra_a  (ram_ra),
        .rd_a  (ram_rd),
        .ra_b  (mem_raddr),
        .rd_b  (mem_rdata)
    );

    expr_tree_nodes u_nodes (
        .def_i  (def_q),
        .leaf_i (leaf_q),
        .low_i  (low_q),
        .mid_i  (mid_q),
        .low_o  (low_d),
        .mid_o  (mid_d),
        .dz_o   (dz_d),
        .root_o (root_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            def_q    <= '0;
            leaf_k   <= '0;
            ptr_q    <= '0;
            leaf_q   <= '0;
            low_q    <= '0;
            mid_q    <= '0;
            result_q <= '0;
            flag_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        def_q   <= expr_def_t'(tbl_rdata);
                        leaf_k  <= '0;
                        state_q <= ST_LEAF;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_LEAF: begin
                    if (def_q.mode[leaf_k] == MODE_IND) begin
                        ptr_q   <= ram_rd;
                        state_q <= ST_IND;
                    end else begin
                        if (def_q.mode[leaf_k] == MODE_DIR)
                            leaf_q[leaf_k] <= ram_rd;
                        else
                            leaf_q[leaf_k] <= def_q.opnd[leaf_k];
                        if (last_leaf) state_q <= ST_L1;
                        else           leaf_k  <= leaf_k + 1'b1;
                    end
                end
                ST_IND: begin
                    leaf_q[leaf_k] <= ram_rd;
                    if (last_leaf) begin
                        state_q <= ST_L1;
                    end else begin
                        leaf_k  <= leaf_k + 1'b1;
                        state_q <= ST_LEAF;
                    end
                end
                ST_L1: begin
                    low_q   <= low_d;
                    err_q   <= err_q | (|dz_d);
                    state_q <= ST_L2;
                end
                ST_L2: begin
                    mid_q   <= mid_d;
                    state_q <= ST_L3;
                end
                ST_L3: begin
                    result_q <= root_d;
                    if (root_is_cmp(def_q.op_root)) flag_q <= root_d[0];
                    state_q <= (def_q.dmode == DEST_STORE) ? ST_STORE : ST_DONE;
                end
                ST_STORE: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = !idle;
    assign done     = (state_q == ST_DONE);
    assign result   = result_q;
    assign cmp_flag = flag_q;
    assign div_err  = err_q;
endmodule

// File: rtl/expr_tree_checker.sv
module expr_tree_checker
    import expr_tree_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result,
    input logic          cmp_flag,
    input logic          div_err,
    input logic [OW-1:0] root_op
);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);

    assert_flag_cmp_only_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_flag) |-> root_is_cmp(root_op));

    assert_cmp_boolean_R5: assert property (@(posedge clk) disable iff (rst)
        (done && root_is_cmp(root_op)) |-> (result <= DW'(1)));

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !div_err && !cmp_flag && result == '0));
endmodule

bind expr_tree_engine expr_tree_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .cmp_flag (cmp_flag),
    .div_err  (div_err),
    .root_op  (def_q.op_root)
);

// File: tb/expr_tree_engine_tb.sv
module expr_tree_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  expr_idx = '0;
    logic        busy, done, cmp_flag, div_err;
    logic [7:0]  result, mem_rdata;
    logic        def_we = 1'b0;
    logic [7:0]  def_waddr = '0;
    logic [87:0] def_wdata = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_waddr = '0, mem_wdata = '0, mem_raddr = '0;

    int nchk = 0, nfail = 0;
    bit reported = 1'b0;

    logic [7:0]  smem [256];
    logic [87:0] sdef [256];
    int exp_flag = 0, exp_err = 0, exp_res = 0;

    always #4 clk = ~clk;

    expr_tree_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .expr_idx(expr_idx),
        .busy(busy), .done(done), .result(result), .cmp_flag(cmp_flag),
        .div_err(div_err), .def_we(def_we), .def_waddr(def_waddr),
        .def_wdata(def_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        end
        $finish;
    endtask

    function automatic logic [87:0] mk(int ll, int lm, int rt, int rm, int rl,
                                       logic [17:0] md, logic [47:0] od, int dm, int da);
        logic [87:0] w = '0;
        w[87:86] = 2'(ll); w[85:84] = 2'(lm); w[83:82] = 2'(rt);
        w[81:80] = 2'(rm); w[79:78] = 2'(rl);
        w[77:60] = md; w[59:12] = od;
        w[11:9] = 3'(dm); w[7:0] = 8'(da);
        return w;
    endfunction

    function automatic int bottom(int op, int a, int b, inout int dz);
        if (op % 2 == 1) begin
            if (b == 0) begin dz = 1; return 255; end
            return a / b;
        end
        return (a * b) % 256;
    endfunction

    function automatic int middle(int op, int a, int b);
        if (op % 2 == 1) return (a - b + 256) % 256;
        return (a + b) % 256;
    endfunction

    task automatic mem_wr(input int a, input int d);
        @(negedge clk);
        mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = 8'(d);
        @(negedge clk);
        mem_we = 1'b0;
        smem[a] = 8'(d);
    endtask

    task automatic def_wr(input int i, input logic [87:0] w);
        @(negedge clk);
        def_we = 1'b1; def_waddr = 8'(i); def_wdata = w;
        @(negedge clk);
        def_we = 1'b0;
        sdef[i] = w;
    endtask

    task automatic mem_check(input int a, input int exp, input string req);
        @(negedge clk);
        mem_raddr = 8'(a);
        #1;
        chk(mem_rdata == 8'(exp), req, int'(mem_rdata), exp);
    endtask

    // reference evaluation, then a cycle-by-cycle comparison of the handshake
    task automatic run(input int idx, input bit poke, input string req);
        logic [87:0] w = sdef[idx];
        int lv[6];
        int nind = 0, dz = 0, st, n, rt, lo_l, lo_r, mid_l, mid_r;
        for (int i = 0; i < 6; i++) begin
            int m = int'(w[77-3*i -: 3]);
            int o = int'(w[59-8*i -: 8]);
            if (m == 0)      lv[i] = int'(smem[o]);
            else if (m == 2) begin lv[i] = int'(smem[smem[o]]); nind++; end
            else             lv[i] = o;
        end
        lo_l  = bottom(int'(w[87:86]), lv[0], lv[1], dz);
        mid_l = middle(int'(w[85:84]), lo_l, lv[2]);
        lo_r  = bottom(int'(w[79:78]), lv[4], lv[5], dz);
        mid_r = middle(int'(w[81:80]), lv[3], lo_r);
        rt = int'(w[83:82]);
        if (rt == 0)      exp_res = (mid_l < mid_r) ? 1 : 0;
        else if (rt == 1) exp_res = (mid_l > mid_r) ? 1 : 0;
        else              exp_res = mid_l & mid_r;
        st = (w[11:9] == 3'd0) ? 1 : 0;
        n  = 6 + nind + 4 + st;
        if (rt < 2) exp_flag = exp_res;
        if (dz != 0) exp_err = 1;

        @(negedge clk);
        start = 1'b1; expr_idx = 8'(idx);
        for (int c = 1; c <= n + 1; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            chk(busy == ((c < n) ? 1'b1 : 1'b0), {req, " R7 busy"}, int'(busy), (c < n) ? 1 : 0);
            chk(done == ((c == n) ? 1'b1 : 1'b0), {req, " R7 done"}, int'(done), (c == n) ? 1 : 0);
            if (c == n) begin
                chk(result == 8'(exp_res), {req, " R9 result"}, int'(result), exp_res);
                chk(cmp_flag == exp_flag[0], {req, " R9 flag"}, int'(cmp_flag), exp_flag);
                chk(div_err == exp_err[0], {req, " R6 err"}, int'(div_err), exp_err);
            end
            if (poke && c == 2) begin
                start = 1'b1; expr_idx = 8'd1;
                def_we = 1'b1; def_waddr = 8'd1; def_wdata = '0;
                mem_we = 1'b1; mem_waddr = 8'd10; mem_wdata = 8'd77;
            end
            if (poke && c == 3) begin
                start = 1'b0; def_we = 1'b0; mem_we = 1'b0;
            end
        end
        if (st == 1) smem[int'(w[7:0])] = 8'(exp_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0,   "R11 busy",   int'(busy), 0);
        chk(done == 1'b0,   "R11 done",   int'(done), 0);
        chk(result == 8'd0, "R11 result", int'(result), 0);
        chk(cmp_flag == 1'b0, "R11 flag", int'(cmp_flag), 0);
        chk(div_err == 1'b0,  "R11 err",  int'(div_err), 0);

        mem_wr(10, 20);  mem_wr(11, 30);  mem_wr(12, 40);
        mem_wr(40, 99);  mem_wr(13, 120); mem_wr(50, 0);

        // R2 R3 R5: count < limit, direct leaves
        def_wr(0, mk(0,0,0,0,0, {3'd0,3'd7,3'd7,3'd0,3'd7,3'd7},
                     {8'd10,8'd1,8'd0,8'd11,8'd1,8'd0}, 7, 0));
        // R8: increment and store back
        def_wr(1, mk(0,0,2,0,0, {3'd0,3'd7,3'd7,3'd7,3'd7,3'd7},
                     {8'd10,8'd1,8'd1,8'd255,8'd1,8'd0}, 0, 10));
        // R3 indirect, R5 greater-than
        def_wr(2, mk(0,0,1,0,0, {3'd2,3'd7,3'd7,3'd0,3'd7,3'd7},
                     {8'd12,8'd1,8'd0,8'd13,8'd1,8'd0}, 7, 0));
        // R3 address-of, R4 divide/subtract/multiply wrap
        def_wr(3, mk(1,1,0,1,0, {3'd1,3'd7,3'd7,3'd7,3'd7,3'd7},
                     {8'd200,8'd4,8'd7,8'd100,8'd20,8'd20}, 7, 0));
        // R6 divide by zero, stored
        def_wr(4, mk(1,0,2,0,0, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7},
                     {8'd77,8'd0,8'd0,8'd15,8'd1,8'd0}, 0, 50));
        // R8 non-store destination mode, R3 mode 4 as literal
        def_wr(5, mk(0,0,2,0,0, {3'd0,3'd7,3'd7,3'd4,3'd7,3'd7},
                     {8'd10,8'd1,8'd1,8'd255,8'd1,8'd0}, 5, 10));

        run(0, 1'b1, "R1 R10 ignored start/writes");   // 20<30 -> 1
        mem_check(10, 20, "R10 mem write while busy");
        run(1, 1'b0, "R8 store");                      // 21 stored
        mem_check(10, 21, "R8 stored byte");
        run(2, 1'b0, "R3 indirect");                   // 99>120 -> 0
        run(3, 1'b0, "R4 wrap");                       // 43<212 -> 1
        run(4, 1'b0, "R6 div zero");                   // 15 stored, err
        mem_check(50, 15, "R6 stored after div zero");
        run(5, 1'b0, "R8 discard");                    // 22, not stored
        mem_check(10, 21, "R8 discard keeps memory");
        run(0, 1'b0, "R6 sticky rerun");               // 21<30 -> 1
        chk(exp_err == 1, "R6 expected sticky", exp_err, 1);

        summary();
    end
endmodule